// File: doc/BRIEF.md
# Acquisition Group Interrupt Flag Controller

This block holds the event and interrupt state of one acquisition group in a 32-bit timed digital-input engine. It sits behind a synchronous byte-wide register bus. Several event pulses come in from the sampling logic: a wait/handshake timeout, a primary terminal count and a secondary terminal count. The block latches each of them into a sticky flag that stays set until software clears it. A FIFO-not-empty level is shown live next to those flags. Software clears the flags through two clear registers, and each of those registers has its own bit layout. One of them also issues single-cycle reset pulses to the DMA logic and to the FIFO.

A transfer counter loaded by software counts sample strobes while the run-mode register is nonzero. When the counter reaches zero, the block raises a sticky count-expired flag and forces the run mode back to zero, which stops sampling. Software can also stop sampling by writing zero to the run-mode register.

An interrupt-enable register uses the same bit positions as the flag register. The interrupt output is the OR of all enabled flags, and it is gated by a master control register whose low two bits select an interrupt line. Writing zero to that register therefore silences the interrupt. Two read-only status registers summarise the pending interrupt and the group state.

Top module: `acq_irq_flags`

## Requirements
- R1: After reset, the flag register, the interrupt-enable register, the run-mode register, the transfer count and the master control register read as zero. The irq, dmaRst and fifoRst outputs are low.
- R2: Reading offset 6 returns the flags. A one-cycle pulse on waitTimeout, primaryTc or secondaryTc sets bit 5, bit 6 or bit 7 respectively, starting in the cycle after the pulse. Each of these bits then stays set until it is cleared.
- R3: A write to offset 6 clears bit 5 when data bit 3 is one, bit 6 when data bit 4 is one, and bit 7 when data bit 5 is one. Other flags are left unchanged. If an event and its clear arrive in the same cycle, the flag ends up set.
- R4: Flag bit 1 (count-expired) is cleared only by writing offset 46 with data bit 0 set. Writes to offset 6 leave it unchanged.
- R5: Flag bit 0 follows the fifoNotEmpty input in the same cycle, without latching.
- R6: The interrupt-enable register at offset 75 is read/write and uses the flag bit positions. irq is high exactly when some flag bit and its enable bit are both one and bits 1:0 of the master register (write offset 5) are nonzero. irqLine outputs master bits 1:0, and irqOpenDrain outputs master bit 2.
- R7: The transfer count is written and read at offsets 20 to 23, least significant byte first. Each sampleStrobe taken while the run mode is nonzero and the count is nonzero decrements the count. The strobe that takes the count from 1 to 0 sets flag bit 1 and writes zero to the run mode.
- R8: While the count is zero, sample strobes do not change the count and do not set flag bit 1, and the run mode stays as written.
- R9: The run-mode register at offset 65 is read/write. While it is zero, sample strobes leave the count unchanged.
- R10: Reading offset 4 returns irq in bit 0. Reading offset 5 returns fifoNotEmpty in bit 0, "run mode nonzero" in bit 2 and flag bit 1 in bit 3. All other bits of both registers read as zero.
- R11: A write to offset 6 with data bit 6 set drives dmaRst high for exactly the next cycle. Data bit 7 does the same for fifoRst.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset for reads and writes |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| fifoNotEmpty | input | 1 | FIFO holds data |
| sampleStrobe | input | 1 | One sample taken |
| waitTimeout | input | 1 | Wait/handshake timeout pulse |
| primaryTc | input | 1 | Primary terminal count pulse |
| secondaryTc | input | 1 | Secondary terminal count pulse |
| irq | output | 1 | Interrupt request |
| irqLine | output | 2 | Selected interrupt line |
| irqOpenDrain | output | 1 | Open-drain output select |
| runActive | output | 1 | Run mode nonzero |
| dmaRst | output | 1 | One-cycle DMA reset pulse |
| fifoRst | output | 1 | One-cycle FIFO reset pulse |

## Verification
A flag that is lost or set by mistake shows up on the next read of offset 6, and on irq in the cycle after the event whenever the flag is enabled. Wrong clear-bit routing is found by sweeping all 256 values of the first clear register over a fully set flag byte. A counter that is off by one makes runActive drop one strobe early or one strobe late. That edge, and flag bit 1, are compared after each strobe of a short count.

// File: rtl/acqf_pkg.sv
package acqf_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int CNT_BYTES  = 4;
  localparam int CNT_W      = 8 * CNT_BYTES;
  localparam int CNT_SEL_W  = $clog2(CNT_BYTES);

  localparam int OFS_STATUS = 4;
  localparam int OFS_MASTER = 5;
  localparam int OFS_FLAGS  = 6;
  localparam int OFS_COUNT  = 20;
  localparam int OFS_CLR2   = 46;
  localparam int OFS_RUN    = 65;
  localparam int OFS_IEN    = 75;

  localparam int F_READY    = 0;
  localparam int F_EXPIRED  = 1;
  localparam int F_WAITED   = 5;
  localparam int F_PTC      = 6;
  localparam int F_STC      = 7;

  localparam int K_WAITED   = 3;
  localparam int K_PTC      = 4;
  localparam int K_STC      = 5;
  localparam int K_DMA      = 6;
  localparam int K_FIFO     = 7;
  localparam int K_EXPIRED  = 0;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_GSTAT, RD_FLAGS, RD_COUNT, RD_RUN, RD_IEN
  } rdSel_e;

  typedef struct packed {
    logic                 wrMaster;
    logic                 wrClr1;
    logic                 wrClr2;
    logic                 wrIen;
    logic                 wrRun;
    logic [CNT_BYTES-1:0] wrCount;
    rdSel_e               rdSel;
    logic [CNT_SEL_W-1:0] cntByte;
  } ctlStrobes_t;
endpackage

// File: rtl/acqf_ctrl.sv
module acqf_ctrl
  import acqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output ctlStrobes_t       strb,
  output logic              dmaRst,
  output logic              fifoRst
);
  logic inCount;
  logic [ADDR_W-1:0] cntOfs;

  assign cntOfs  = regAddr - ADDR_W'(OFS_COUNT);
  assign inCount = (regAddr >= ADDR_W'(OFS_COUNT)) &&
                   (regAddr <  ADDR_W'(OFS_COUNT + CNT_BYTES));

  always_comb begin
    strb.wrMaster = regWr && (regAddr == ADDR_W'(OFS_MASTER));
    strb.wrClr1   = regWr && (regAddr == ADDR_W'(OFS_FLAGS));
    strb.wrClr2   = regWr && (regAddr == ADDR_W'(OFS_CLR2));
    strb.wrIen    = regWr && (regAddr == ADDR_W'(OFS_IEN));
    strb.wrRun    = regWr && (regAddr == ADDR_W'(OFS_RUN));
    strb.cntByte  = cntOfs[CNT_SEL_W-1:0];
    if      (regAddr == ADDR_W'(OFS_STATUS)) strb.rdSel = RD_STATUS;
    else if (regAddr == ADDR_W'(OFS_MASTER)) strb.rdSel = RD_GSTAT;
    else if (regAddr == ADDR_W'(OFS_FLAGS))  strb.rdSel = RD_FLAGS;
    else if (regAddr == ADDR_W'(OFS_RUN))    strb.rdSel = RD_RUN;
    else if (regAddr == ADDR_W'(OFS_IEN))    strb.rdSel = RD_IEN;
    else if (inCount)                        strb.rdSel = RD_COUNT;
    else                                     strb.rdSel = RD_NONE;
  end

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cntLane
    assign strb.wrCount[b] = regWr && (regAddr == ADDR_W'(OFS_COUNT + b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmaRst  <= 1'b0;
      fifoRst <= 1'b0;
    end else begin
      dmaRst  <= strb.wrClr1 && regWdata[K_DMA];
      fifoRst <= strb.wrClr1 && regWdata[K_FIFO];
    end
  end
endmodule

// File: rtl/acqf_datapath.sv
module acqf_datapath
  import acqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              fifoNotEmpty,
  input  logic              sampleStrobe,
  input  logic              waitTimeout,
  input  logic              primaryTc,
  input  logic              secondaryTc,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic [2:0]        masterQ,
  output logic [DATA_W-1:0] flagsView,
  output logic [DATA_W-1:0] runQ,
  output logic [CNT_W-1:0]  countQ
);
  localparam logic [DATA_W-1:0] STICKY_MASK =
    DATA_W'((1 << F_EXPIRED) | (1 << F_WAITED) | (1 << F_PTC) | (1 << F_STC));

  logic [DATA_W-1:0] stickyQ, ienQ, setVec, clrVec;
  logic [CNT_W-1:0]  cntNext;
  logic running, countDec, expireEvt;

  assign running   = |runQ;
  assign countDec  = running && sampleStrobe && (countQ != '0) && !(|strb.wrCount);
  assign expireEvt = countDec && (countQ == CNT_W'(1));

  always_comb begin
    setVec = '0;
    setVec[F_EXPIRED] = expireEvt;
    setVec[F_WAITED]  = waitTimeout;
    setVec[F_PTC]     = primaryTc;
    setVec[F_STC]     = secondaryTc;
    clrVec = '0;
    clrVec[F_EXPIRED] = strb.wrClr2 && regWdata[K_EXPIRED];
    clrVec[F_WAITED]  = strb.wrClr1 && regWdata[K_WAITED];
    clrVec[F_PTC]     = strb.wrClr1 && regWdata[K_PTC];
    clrVec[F_STC]     = strb.wrClr1 && regWdata[K_STC];
  end

  always_comb begin
    cntNext = countDec ? countQ - CNT_W'(1) : countQ;
    for (int b = 0; b < CNT_BYTES; b++)
      if (strb.wrCount[b]) cntNext[b*8 +: 8] = regWdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stickyQ <= '0;
      ienQ    <= '0;
      masterQ <= '0;
      runQ    <= '0;
      countQ  <= '0;
    end else begin
      stickyQ <= ((stickyQ & ~clrVec) | setVec) & STICKY_MASK;
      countQ  <= cntNext;
      if (strb.wrIen)    ienQ    <= regWdata;
      if (strb.wrMaster) masterQ <= regWdata[2:0];
      if (expireEvt)       runQ <= '0;
      else if (strb.wrRun) runQ <= regWdata;
    end
  end

  always_comb begin
    flagsView = stickyQ;
    flagsView[F_READY] = fifoNotEmpty;
  end

  assign irq = (masterQ[1:0] != 2'b00) && |(flagsView & ienQ);

  always_comb begin
    regRdata = '0;
    unique case (strb.rdSel)
      RD_STATUS: regRdata[0] = irq;
      RD_GSTAT: begin
        regRdata[0] = fifoNotEmpty;
        regRdata[2] = running;
        regRdata[3] = stickyQ[F_EXPIRED];
      end
      RD_FLAGS: regRdata = flagsView;
      RD_COUNT: regRdata = countQ[strb.cntByte*8 +: 8];
      RD_RUN:   regRdata = runQ;
      RD_IEN:   regRdata = ienQ;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/acq_irq_flags.sv
module acq_irq_flags
  import acqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              fifoNotEmpty,
  input  logic              sampleStrobe,
  input  logic              waitTimeout,
  input  logic              primaryTc,
  input  logic              secondaryTc,
  output logic              irq,
  output logic [1:0]        irqLine,
  output logic              irqOpenDrain,
  output logic              runActive,
  output logic              dmaRst,
  output logic              fifoRst
);
  ctlStrobes_t       strb;
  logic [2:0]        masterQ;
  logic [DATA_W-1:0] flagsView, runQ;
  logic [CNT_W-1:0]  countQ;

  acqf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb), .dmaRst(dmaRst), .fifoRst(fifoRst)
  );

  acqf_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regWdata(regWdata),
    .fifoNotEmpty(fifoNotEmpty), .sampleStrobe(sampleStrobe),
    .waitTimeout(waitTimeout), .primaryTc(primaryTc), .secondaryTc(secondaryTc),
    .regRdata(regRdata), .irq(irq), .masterQ(masterQ), .flagsView(flagsView),
    .runQ(runQ), .countQ(countQ)
  );

  assign irqLine      = masterQ[1:0];
  assign irqOpenDrain = masterQ[2];
  assign runActive    = |runQ;
endmodule

// File: rtl/acq_irq_flags_chk.sv
module acq_irq_flags_chk
  import acqf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              waitTimeout,
  input logic              irq,
  input logic              dmaRst,
  input logic [2:0]        masterQ,
  input logic [DATA_W-1:0] flagsView,
  input logic [DATA_W-1:0] runQ,
  input logic [CNT_W-1:0]  countQ
);
  logic clrWaited, cntWrite;
  assign clrWaited = regWr && (regAddr == ADDR_W'(OFS_FLAGS)) && regWdata[K_WAITED];
  assign cntWrite  = regWr && (regAddr >= ADDR_W'(OFS_COUNT)) &&
                     (regAddr < ADDR_W'(OFS_COUNT + CNT_BYTES));

  a_r2_waited_sets: assert property (@(posedge clk) disable iff (!rst_n)
    waitTimeout |=> flagsView[F_WAITED]);

  a_r3_waited_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flagsView[F_WAITED] && !clrWaited) |=> flagsView[F_WAITED]);

  a_r7_expiry_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagsView[F_EXPIRED]) |-> (runQ == '0));

  a_r6_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (masterQ[1:0] == 2'b00) |-> !irq);

  a_r11_dma_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dmaRst |-> $past(regWr && (regAddr == ADDR_W'(OFS_FLAGS)) && regWdata[K_DMA]));

  a_r8_zero_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((countQ == '0) && !cntWrite) |=> (countQ == '0));
endmodule

bind acq_irq_flags acq_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .waitTimeout(waitTimeout), .irq(irq), .dmaRst(dmaRst),
  .masterQ(masterQ), .flagsView(flagsView), .runQ(runQ), .countQ(countQ)
);

// File: tb/acq_irq_flags_tb.sv
module acq_irq_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic fifoNotEmpty = 1'b0, sampleStrobe = 1'b0, waitTimeout = 1'b0;
  logic primaryTc = 1'b0, secondaryTc = 1'b0;
  logic irq, irqOpenDrain, runActive, dmaRst, fifoRst;
  logic [1:0] irqLine;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acq_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .fifoNotEmpty(fifoNotEmpty),
    .sampleStrobe(sampleStrobe), .waitTimeout(waitTimeout),
    .primaryTc(primaryTc), .secondaryTc(secondaryTc), .irq(irq),
    .irqLine(irqLine), .irqOpenDrain(irqOpenDrain), .runActive(runActive),
    .dmaRst(dmaRst), .fifoRst(fifoRst)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  // pulses events: bit0 wait, bit1 ptc, bit2 stc, bit3 sample
  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    {sampleStrobe, secondaryTc, primaryTc, waitTimeout} = ev;
    @(negedge clk);
    {sampleStrobe, secondaryTc, primaryTc, waitTimeout} = '0;
  endtask

  task automatic wrCount(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(8'(20 + b), v[b*8 +: 8]);
  endtask

  task automatic rdCount(output logic [31:0] v);
    logic [7:0] t;
    for (int b = 0; b < 4; b++) begin rd(8'(20 + b), t); v[b*8 +: 8] = t; end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(6, d);  chk("R1 flags", d, 0);
    rd(75, d); chk("R1 ien", d, 0);
    rd(65, d); chk("R1 run", d, 0);
    rdCount(c); chk("R1 count", c, 0);
    chk("R1 outputs", {irq, irqLine, irqOpenDrain, dmaRst, fifoRst}, 0);

    // R5 ready follows input
    fifoNotEmpty = 1'b1; rd(6, d); chk("R5 ready high", d, 8'h01);
    rd(5, d); chk("R10 gstat data-left", d, 8'h01);
    fifoNotEmpty = 1'b0; rd(6, d); chk("R5 ready low", d, 8'h00);

    // R2/R6 sweep: event subsets x enable patterns
    wr(5, 8'h05);
    chk("R6 irqLine", irqLine, 2'd1);
    chk("R6 open drain", irqOpenDrain, 1'b1);
    for (int ev = 0; ev < 8; ev++) begin
      for (int ep = 0; ep < 8; ep++) begin
        logic [7:0] en, fl;
        en = {ep[2:0], 5'b0};
        fl = {ev[2:0], 5'b0};
        wr(6, 8'h38);
        wr(75, en);
        pulse({1'b0, ev[2:0]});
        rd(6, d); chk("R2 flags after events", d, fl);
        chk("R6 irq", irq, |(fl & en));
        rd(4, d); chk("R10 status irq", d, {7'b0, |(fl & en)});
      end
    end
    // R2 sticky: still set many cycles later
    wr(75, 8'h00); pulse(4'b0111);
    repeat (5) @(negedge clk);
    rd(6, d); chk("R2 sticky hold", d, 8'hE0);

    // R6 master zero silences
    wr(75, 8'hE0); chk("R6 irq on", irq, 1'b1);
    wr(5, 8'h00); chk("R6 irq masked by master", irq, 1'b0);
    wr(5, 8'h02); chk("R6 irq re-enabled", irq, 1'b1);

    // R3 clear sweep over all 256 values (bits 6/7 pulses also checked: R11)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] exp;
      pulse(4'b0111);
      wr(6, 8'(v));
      chk("R11 dma pulse", dmaRst, v[6]);
      chk("R11 fifo pulse", fifoRst, v[7]);
      exp = 8'hE0;
      if (v[3]) exp[5] = 1'b0;
      if (v[4]) exp[6] = 1'b0;
      if (v[5]) exp[7] = 1'b0;
      rd(6, d); chk("R3 clear map", d, exp);
    end
    @(negedge clk);
    chk("R11 pulse single cycle", {dmaRst, fifoRst}, 2'b00);

    // R3 set wins over clear
    wr(6, 8'h38);
    @(negedge clk);
    regWr = 1'b1; regAddr = 6; regWdata = 8'h08; waitTimeout = 1'b1;
    @(negedge clk);
    regWr = 1'b0; waitTimeout = 1'b0;
    rd(6, d); chk("R3 set wins", d, 8'h20);
    wr(6, 8'h38);

    // R7 count
    wrCount(32'h0102_0304);
    rdCount(c); chk("R7 count byte order", c, 32'h0102_0304);
    // R9 run zero: no decrement
    pulse(4'b1000); pulse(4'b1000);
    rdCount(c); chk("R9 idle no decrement", c, 32'h0102_0304);
    wrCount(3);
    wr(65, 8'h07);
    rd(65, d); chk("R9 run readback", d, 8'h07);
    pulse(4'b1000); pulse(4'b1000);
    rdCount(c); chk("R7 decrement", c, 1);
    rd(6, d); chk("R7 not yet expired", d[1], 1'b0);
    chk("R7 still running", runActive, 1'b1);
    pulse(4'b1000);
    rdCount(c); chk("R7 reached zero", c, 0);
    rd(6, d); chk("R7 expired flag", d[1], 1'b1);
    rd(65, d); chk("R7 run cleared", d, 8'h00);
    chk("R7 runActive low", runActive, 1'b0);
    rd(5, d); chk("R10 gstat expired", d, 8'h08);

    // R4 expired clearing
    wr(6, 8'hFF);
    rd(6, d); chk("R4 first clear keeps expired", d[1], 1'b1);
    wr(46, 8'h01);
    rd(6, d); chk("R4 second clear", d[1], 1'b0);

    // R8 count zero free running
    wr(65, 8'h01);
    pulse(4'b1000); pulse(4'b1000);
    rdCount(c); chk("R8 count stays zero", c, 0);
    rd(6, d); chk("R8 no expiry", d[1], 1'b0);
    rd(5, d); chk("R10 gstat running", d, 8'h04);

    // R12 unmapped
    rd(100, d); chk("R12 unmapped", d, 0);
    rd(46, d); chk("R12 clear2 reads zero", d, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule